// File: doc/BRIEF.md
# Endian-Configurable Load Aligner

This block sits on the load path between a byte-addressed memory that is read one aligned 64-bit line at a time and a 64-bit register file. A request carries a byte address, a size code, a signed/unsigned flag and a byte-order mode. The block reads the aligned line or lines that hold the requested bytes and assembles them in the chosen byte order. It then widens the value to 64 bits by zero fill or sign replication.

An access whose bytes all fall inside one aligned 8-byte line takes a single read. An access that runs past the end of its line is split into two aligned reads: first the line holding the start address, then the next line. The two lines are merged before the bytes are picked out. Only one request is handled at a time. The request side uses a valid/ready handshake, and the result comes back with a one-cycle done pulse. The memory returns read data exactly one cycle after the read is issued.

Top module: `load_aligner`

## Requirements
- R1: After reset, `req_ready` is 1, `done` is 0 and `mem_rd_en` is 0. `req_ready` is 0 from the cycle after a request is accepted (an edge with `req_valid` and `req_ready` both 1) through the cycle in which `done` is 1.
- R2: A request whose byte span does not cross an 8-byte line issues exactly one read, with `mem_rd_addr` equal to address >> 3, in the cycle right after acceptance. `done` is 1 in the third cycle after acceptance.
- R3: A request with (address mod 8) + size in bytes > 8 issues two reads in consecutive cycles, first at line address >> 3 and then at line (address >> 3) + 1. `done` is 1 in the fourth cycle after acceptance.
- R4: With `req_big` = 0 (little-endian), the byte at the lowest address lands in result bits [7:0] and each following byte in the next higher 8 bits. For example, memory bytes f0..f7 at address 0 with a 4-byte unsigned load give 0x00000000f3f2f1f0.
- R5: With `req_big` = 1 (big-endian), the byte at the lowest address becomes the most significant byte of the loaded value. The same example gives 0x00000000f0f1f2f3.
- R6: With `req_signed` = 0, every result bit above the access width is 0.
- R7: With `req_signed` = 1, every result bit above the access width copies the top bit of the assembled value.
- R8: `done` lasts one cycle per accepted request, and `result` is valid in that cycle.
- R9: `req_valid`, and a changed address, while `req_ready` is 0 are ignored. The result of the request in flight is unaffected, and no further request starts.
- R10: Size codes on `req_size` are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. Memory byte at line offset k is carried on `mem_rd_data[8k+7:8k]`. An 8-byte load at a multiple of 8 returns the full line in the selected order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_addr | input | AW (32) | Byte address of the load |
| req_size | input | 2 | Size code: 0=1, 1=2, 2=4, 3=8 bytes |
| req_signed | input | 1 | 1 = sign-extend, 0 = zero-extend |
| req_big | input | 1 | 1 = big-endian, 0 = little-endian |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | AW-3 (29) | Aligned line index to read |
| mem_rd_data | input | 64 | Line data, valid the cycle after the strobe |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Loaded, ordered and extended value |

## Verification
Counted from the clock edge that accepts a request, the first read strobe is due in the next cycle. A split access's second strobe is due one cycle later, and `done` is due in the third cycle for a single-line access or the fourth for a split one. The bench drives at falling edges and samples each cycle at the falling edge after acceptance. It logs every strobe and its line index by cycle number and compares the cycle in which `done` appears against the count the requirements give. `result` is checked in that done cycle, against values built in the bench from a known byte pattern in which each address holds its own byte.

// File: rtl/la_pkg.sv
// Package: shared types for the load aligner.
// Assumes a 2-bit size code where the code is log2 of the byte count.
package la_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } la_size_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ISSUE = 3'd1,
        ST_CAP0  = 3'd2,
        ST_CAP1  = 3'd3,
        ST_FIN   = 3'd4
    } la_state_e;
endpackage

// File: rtl/la_ctrl.sv
// Sequencer for the load aligner.
// Accepts one request, issues one or two aligned line reads, captures the
// returned lines and raises done for one cycle.
// Assumes memory data is valid exactly one cycle after mem_rd_en.
module la_ctrl
    import la_pkg::*;
#(
    parameter int AW   = 32,
    parameter int DW   = 64,
    parameter int OFFW = $clog2(DW / 8),
    parameter int LW   = AW - OFFW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic [AW-1:0]  req_addr,
    input  logic [1:0]     req_size,
    input  logic           req_signed,
    input  logic           req_big,
    output logic           mem_rd_en,
    output logic [LW-1:0]  mem_rd_addr,
    input  logic [DW-1:0]  mem_rd_data,
    output logic           done,
    output logic [DW-1:0]  lo_q,
    output logic [DW-1:0]  hi_q,
    output logic [OFFW-1:0] off_q,
    output la_size_e       size_q,
    output logic           signed_q,
    output logic           big_q
);
    localparam int BYTES = DW / 8;
    localparam int SPW   = OFFW + 2;

    la_state_e       st;
    logic [LW-1:0]   line_q;
    logic            split_q;
    logic [SPW-1:0]  span;
    logic            accept;

    // Request acceptance and crossing detection.
    always_comb begin
        accept = req_valid && (st == ST_IDLE);
        span   = SPW'(req_addr[OFFW-1:0]) + (SPW'(1) << req_size);
    end

    // Handshake, memory strobe and line index by state.
    always_comb begin
        req_ready   = (st == ST_IDLE);
        done        = (st == ST_FIN);
        mem_rd_en   = (st == ST_ISSUE) || ((st == ST_CAP0) && split_q);
        mem_rd_addr = (st == ST_CAP0) ? line_q + LW'(1) : line_q;
    end

    // State sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            case (st)
                ST_IDLE:  if (accept) st <= ST_ISSUE;
                ST_ISSUE: st <= ST_CAP0;
                ST_CAP0:  st <= split_q ? ST_CAP1 : ST_FIN;
                ST_CAP1:  st <= ST_FIN;
                default:  st <= ST_IDLE;
            endcase
        end
    end

    // Request field latch on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q   <= '0;
            off_q    <= '0;
            size_q   <= SZ_BYTE;
            signed_q <= 1'b0;
            big_q    <= 1'b0;
            split_q  <= 1'b0;
        end else if (accept) begin
            line_q   <= req_addr[AW-1:OFFW];
            off_q    <= req_addr[OFFW-1:0];
            size_q   <= la_size_e'(req_size);
            signed_q <= req_signed;
            big_q    <= req_big;
            split_q  <= (span > SPW'(BYTES));
        end
    end

    // Line capture as read data returns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (st == ST_CAP0) lo_q <= mem_rd_data;
            if (st == ST_CAP1) hi_q <= mem_rd_data;
        end
    end

    // R8: done never lasts two cycles.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1: not ready while a result is being returned.
    p_busy_at_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_ready);

    // R3: back-to-back strobes target consecutive lines.
    p_next_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && $past(mem_rd_en)) |-> (mem_rd_addr == $past(mem_rd_addr) + LW'(1)));

    // R2: no memory traffic while idle.
    p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_rd_en);

    // R9: acceptance always leads to a busy cycle next.
    p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
endmodule

// File: rtl/la_window.sv
// Byte window selector.
// Forms a two-line window with the first line in the low half and takes the
// line-width run of bytes that starts at the byte offset.
// Assumes the offset is below one line width.
module la_window #(
    parameter int DW   = 64,
    parameter int OFFW = $clog2(DW / 8)
) (
    input  logic [DW-1:0]   lo,
    input  logic [DW-1:0]   hi,
    input  logic [OFFW-1:0] off,
    output logic [DW-1:0]   raw
);
    localparam int BYTES = DW / 8;

    logic [2*DW-1:0] win;

    // Byte run extraction from the combined window.
    always_comb begin
        win = {hi, lo};
        raw = '0;
        for (int i = 0; i < BYTES; i++) begin
            raw[8*i +: 8] = win[8*(int'(off) + i) +: 8];
        end
    end
endmodule

// File: rtl/la_order_ext.sv
// Byte orderer and widener.
// Takes bytes in address order (byte 0 = lowest address), places them by the
// byte-order mode, then fills the upper bytes with zero or sign copies.
// Assumes the size code is log2 of the byte count and fits the data width.
module la_order_ext
    import la_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic [DW-1:0] raw,
    input  la_size_e      size,
    input  logic          sgn,
    input  logic          big,
    output logic [DW-1:0] val
);
    localparam int BYTES = DW / 8;

    logic [DW-1:0] ordered;
    logic          fill;
    int            nb;

    // Byte placement by mode.
    always_comb begin
        nb      = 1 << int'(size);
        ordered = '0;
        for (int i = 0; i < BYTES; i++) begin
            if (i < nb) begin
                if (big) ordered[8*(nb-1-i) +: 8] = raw[8*i +: 8];
                else     ordered[8*i +: 8]        = raw[8*i +: 8];
            end
        end
    end

    // Widening above the access width.
    always_comb begin
        fill = sgn && ordered[8*nb-1];
        val  = '0;
        for (int i = 0; i < BYTES; i++) begin
            val[8*i +: 8] = (i < nb) ? ordered[8*i +: 8] : {8{fill}};
        end
    end
endmodule

// File: rtl/load_aligner.sv
// Top of the load aligner.
// Connects the sequencer, the byte window and the orderer/widener.
// Assumes a 64-bit line; one request in flight at a time.
module load_aligner
    import la_pkg::*;
#(
    parameter int AW   = 32,
    parameter int DW   = 64,
    parameter int OFFW = $clog2(DW / 8),
    parameter int LW   = AW - OFFW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_size,
    input  logic          req_signed,
    input  logic          req_big,
    output logic          mem_rd_en,
    output logic [LW-1:0] mem_rd_addr,
    input  logic [DW-1:0] mem_rd_data,
    output logic          done,
    output logic [DW-1:0] result
);
    logic [DW-1:0]   lo_q, hi_q, raw;
    logic [OFFW-1:0] off_q;
    la_size_e        size_q;
    logic            signed_q, big_q;

    la_ctrl #(.AW(AW), .DW(DW), .OFFW(OFFW), .LW(LW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .req_size   (req_size),
        .req_signed (req_signed),
        .req_big    (req_big),
        .mem_rd_en  (mem_rd_en),
        .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data),
        .done       (done),
        .lo_q       (lo_q),
        .hi_q       (hi_q),
        .off_q      (off_q),
        .size_q     (size_q),
        .signed_q   (signed_q),
        .big_q      (big_q)
    );

    la_window #(.DW(DW), .OFFW(OFFW)) u_win (
        .lo (lo_q),
        .hi (hi_q),
        .off(off_q),
        .raw(raw)
    );

    la_order_ext #(.DW(DW)) u_ord (
        .raw (raw),
        .size(size_q),
        .sgn (signed_q),
        .big (big_q),
        .val (result)
    );

    // R6: unsigned byte and halfword results carry zeros above their width.
    p_zero_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !signed_q && size_q == SZ_BYTE) |-> (result[DW-1:8] == '0));
    p_zero_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !signed_q && size_q == SZ_HALF) |-> (result[DW-1:16] == '0));

    // R7: signed byte and word results copy their top bit upward.
    p_sign_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && signed_q && size_q == SZ_BYTE) |-> (result[DW-1:8] == {(DW-8){result[7]}}));
    p_sign_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && signed_q && size_q == SZ_WORD) |-> (result[DW-1:32] == {(DW-32){result[31]}}));
endmodule

// File: tb/sim_load_aligner.sv
module sim_load_aligner;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_signed = 1'b0;
    logic        req_big = 1'b0;
    logic        mem_rd_en;
    logic [28:0] mem_rd_addr;
    logic [63:0] mem_rd_data = '0;
    logic        done;
    logic [63:0] result;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    load_aligner u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_signed(req_signed),
        .req_big(req_big), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .done(done), .result(result)
    );

    // Memory: byte at address a holds f0 + a (mod 256); 32 lines.
    function automatic logic [7:0] mbyte(input logic [31:0] a);
        return 8'hf0 + a[7:0];
    endfunction

    always @(posedge clk) begin
        if (mem_rd_en) begin
            for (int k = 0; k < 8; k++)
                mem_rd_data[8*k +: 8] <= mbyte({mem_rd_addr[4:0], 3'(k)});
        end
    end

    function automatic logic [63:0] model(input logic [31:0] a, input int sz,
                                          input bit sg, input bit bg);
        logic [63:0] v = '0;
        int n = 1 << sz;
        for (int i = 0; i < n; i++) begin
            if (bg) v = (v << 8) | 64'(mbyte(a + 32'(i)));
            else    v[8*i +: 8] = mbyte(a + 32'(i));
        end
        if (sg && v[8*n-1])
            for (int i = n; i < 8; i++) v[8*i +: 8] = 8'hff;
        return v;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One load with full timing, strobe and result checks.
    task automatic do_load(input logic [31:0] a, input int sz, input bit sg,
                           input bit bg, input bit poke, input string tag);
        bit split = (int'(a[2:0]) + (1 << sz)) > 8;
        int exp_done = split ? 3 : 2;
        int nreads = 0;
        int done_at = -1;
        bit busy_ok = 1'b1;
        logic [28:0] ra [2];
        logic [63:0] got = '0;
        @(negedge clk);
        req_addr = a; req_size = 2'(sz); req_signed = sg; req_big = bg; req_valid = 1'b1;
        @(negedge clk);
        if (poke) begin
            req_addr = a + 32'd40; req_big = ~bg;
        end else req_valid = 1'b0;
        for (int j = 0; j < 8; j++) begin
            if (!req_ready && j == 0) ; else if (j == 0) busy_ok = 1'b0;
            if (mem_rd_en) begin
                if (nreads < 2) ra[nreads] = mem_rd_addr;
                nreads++;
            end
            if (done) begin
                done_at = j;
                got = result;
                if (req_ready) busy_ok = 1'b0;
                req_valid = 1'b0;
                break;
            end
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk);
        end
        check({tag, " R1 ready low while busy"}, 64'(busy_ok), 64'd1);
        check({tag, split ? " R3 done cycle" : " R2 done cycle"}, 64'(done_at), 64'(exp_done));
        check({tag, split ? " R3 read count" : " R2 read count"}, 64'(nreads), split ? 64'd2 : 64'd1);
        check({tag, " R2 first line"}, 64'(ra[0]), 64'(a[31:3]));
        if (split) check({tag, " R3 second line"}, 64'(ra[1]), 64'(a[31:3]) + 64'd1);
        check({tag, " result"}, got, model(a, sz, sg, bg));
        @(negedge clk);
        check({tag, " R8 done one cycle"}, 64'(done), 64'd0);
        if (poke) begin
            @(negedge clk);
            check({tag, " R9 no new request started"}, 64'(mem_rd_en), 64'd0);
        end
    endtask

    task automatic t_reset;
        check("R1 reset ready", 64'(req_ready), 64'd1);
        check("R1 reset done", 64'(done), 64'd0);
        check("R1 reset strobe", 64'(mem_rd_en), 64'd0);
    endtask

    task automatic t_order;
        do_load(32'd0, 2, 1'b0, 1'b0, 1'b0, "R4 le word");
        check("R4 example", model(32'd0, 2, 1'b0, 1'b0), 64'h00000000f3f2f1f0);
        do_load(32'd0, 2, 1'b0, 1'b1, 1'b0, "R5 be word");
        check("R5 example", model(32'd0, 2, 1'b0, 1'b1), 64'h00000000f0f1f2f3);
        do_load(32'd10, 1, 1'b0, 1'b1, 1'b0, "R5 be half");
        do_load(32'd18, 1, 1'b0, 1'b0, 1'b0, "R4 le half");
    endtask

    task automatic t_extend;
        do_load(32'd3, 0, 1'b0, 1'b0, 1'b0, "R6 zero byte");
        do_load(32'd3, 0, 1'b1, 1'b0, 1'b0, "R7 sign byte");
        do_load(32'd20, 0, 1'b1, 1'b0, 1'b0, "R7 positive byte");
        do_load(32'd4, 2, 1'b1, 1'b1, 1'b0, "R7 sign word be");
        do_load(32'd12, 1, 1'b0, 1'b1, 1'b0, "R6 zero half");
    endtask

    task automatic t_split;
        do_load(32'd6, 2, 1'b0, 1'b0, 1'b0, "R3 le word cross");
        do_load(32'd7, 1, 1'b1, 1'b1, 1'b0, "R3 be half cross");
        do_load(32'd13, 3, 1'b0, 1'b1, 1'b0, "R3 be dbl cross");
        do_load(32'd9, 3, 1'b0, 1'b0, 1'b0, "R3 le dbl cross");
    endtask

    task automatic t_double;
        do_load(32'd16, 3, 1'b0, 1'b0, 1'b0, "R10 le dbl");
        do_load(32'd16, 3, 1'b1, 1'b1, 1'b0, "R10 be dbl");
        do_load(32'd4, 2, 1'b0, 1'b0, 1'b0, "R2 word at line end");
    endtask

    task automatic t_busy;
        do_load(32'd5, 2, 1'b0, 1'b1, 1'b1, "R9 poke split");
        do_load(32'd8, 1, 1'b1, 1'b0, 1'b1, "R9 poke single");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order();
        t_extend();
        t_split();
        t_double();
        t_busy();
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule